// File: doc/BRIEF.md
# Two-Channel Time-Shared Sine/Cosine Synthesizer

This block generates sine and cosine waveforms for two independent channels. Both channels share one phase pipeline and one amplitude table, and they take turns one clock at a time. Each channel's output is therefore refreshed every second clock. At a 100 MHz system clock this gives each channel 50 MHz.

Every clock, the block advances the phase of the channel whose turn it is by that channel's step size, adds the channel's phase shift, and uses the upper phase bits to look up the sine and cosine amplitudes. The amplitudes are 10-bit signed values. Each one is sign-extended into a 16-bit half of a 32-bit output word. A second output port carries the 16-bit phase that produced each word.

Step sizes and phase shifts are loaded over a streaming configuration input. A packet holds one 32-bit beat per channel and ends with a last-beat marker. The block reports a misplaced or absent marker on two single-cycle event outputs. For example, a step of 1310 gives roughly 1 MHz per channel. The frequency is truncated, not exact.

Top module: `dds_tdm2`

## Requirements
- R1: After reset, output beats alternate strictly between channels, starting with channel 0. Between two consecutive beats of the same channel, that channel's phase grows by its active step size.
- R2: The reported phase equals the channel's accumulated phase plus its phase shift, modulo 2^16. Both accumulators are zero after reset.
- R3: While reset is low, and for the first two clock edges after it is released, both valid outputs stay low. They rise on the third edge after release and then stay high every cycle.
- R4: In each output word, cosine sits in bits [15:0] and sine in bits [31:16]. Each is a 10-bit two's-complement value whose sign fills the upper six bits of its half.
- R5: The amplitudes follow 511·sin and 511·cos of the angle 2π·k/1024, where k is phase bits [15:6], to within 2 LSB. The value -512 never appears. At k = 0, 256, 512 and 768, the (sine, cosine) pair is exactly (0, 511), (511, 0), (0, -511) and (-511, 0).
- R6: A configuration beat carries the step size in bits [15:0] and the phase shift in bits [31:16]. The first beat of a packet is for channel 0 and the second is for channel 1.
- R7: The values of a packet take effect for both channels together, from the phase computed on the clock edge after the packet's second beat is accepted. After only the first beat, the previous values stay fully in use.
- R8: If the second beat of a packet arrives without the last marker, the absent-marker event is high for exactly the next cycle. The packet is still applied.
- R9: If the first beat of a packet carries the last marker, the early-marker event is high for exactly the next cycle. The beat still counts as channel 0's beat. The two events never assert together.
- R10: The configuration data and last marker are ignored in any cycle where the configuration valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_cfg_tvalid | input | 1 | Configuration beat present |
| s_cfg_tdata | input | 32 | Step size [15:0], phase shift [31:16] |
| s_cfg_tlast | input | 1 | Marks the last beat of a packet |
| m_wave_tvalid | output | 1 | Amplitude word valid |
| m_wave_tdata | output | 32 | Sine [31:16], cosine [15:0], sign-extended |
| m_phase_tvalid | output | 1 | Phase word valid |
| m_phase_tdata | output | 16 | Phase of the channel in the same beat |
| err_last_absent | output | 1 | One-cycle pulse: last marker missing on second beat |
| err_last_early | output | 1 | One-cycle pulse: last marker on first beat |

## Verification
The assertions check four things on every cycle:
- the exact fill latency and the continuous valid that follows it;
- the sign-extension layout of both amplitude fields and the absence of the most negative code;
- that each framing event traces back to a beat of the matching kind on the previous edge;
- that the two framing events are mutually exclusive.

Only the bench scenarios can show the cycle at which a packet takes effect, that both channels switch together, the channel alternation, the phase arithmetic and its wrap-around, amplitude accuracy against a real-valued sine, and that idle configuration cycles are ignored. The bench exercises these by comparing every beat with a reference that runs alongside the design.

// File: rtl/dds_tdm2_pkg.sv
// Package: shared elaboration-time helpers for the time-shared synthesizer.
// Assumes: callers pass table sizes that are powers of two.
package dds_tdm2_pkg;

    // Quarter-wave magnitude at index k of qn steps per quarter, full scale amax.
    // Uses a rational sine approximation in pure integer arithmetic, so the
    // table can be built at elaboration without real-number support.
    function automatic int unsigned qwave_mag(
        input longint unsigned k,
        input longint unsigned qn,
        input longint unsigned amax
    );
        longint unsigned n;
        longint unsigned prod;
        longint unsigned num;
        longint unsigned den;
        n    = 64'd2 * qn;
        prod = k * (n - k);
        num  = 64'd16 * amax * prod;
        den  = 64'd5 * n * n - 64'd4 * prod;
        return 32'((64'd2 * num + den) / (64'd2 * den));
    endfunction

endpackage

// File: rtl/dds_tdm2_cfg.sv
// Module: configuration packet receiver.
// Collects one beat per channel and commits all channels together on the
// last-channel beat. It also flags a misplaced or absent last marker.
// Assumes: NUM_CH >= 2; beats with valid low carry no meaning.
module dds_tdm2_cfg #(
    parameter int PHASE_W = 16,
    parameter int NUM_CH  = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BEAT_W = 2 * PHASE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              beat_valid,
    input  logic [BEAT_W-1:0]                 beat_data,
    input  logic                              beat_last,
    output logic [NUM_CH-1:0][PHASE_W-1:0]    step,
    output logic [NUM_CH-1:0][PHASE_W-1:0]    shift,
    output logic                              err_absent,
    output logic                              err_early
);

    logic [CH_W-1:0]                  beat_idx;
    logic [NUM_CH-2:0][BEAT_W-1:0]    pend;
    logic                             at_last;

    // Purpose: tell whether the incoming beat is the last channel's beat.
    always_comb at_last = (beat_idx == CH_W'(NUM_CH - 1));

    // Purpose: hold early beats, commit the whole packet, and raise the framing events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_idx   <= '0;
            pend       <= '0;
            step       <= '0;
            shift      <= '0;
            err_absent <= 1'b0;
            err_early  <= 1'b0;
        end else begin
            err_absent <= 1'b0;
            err_early  <= 1'b0;
            if (beat_valid) begin
                if (at_last) begin
                    for (int j = 0; j < NUM_CH - 1; j++) begin
                        step[j]  <= pend[j][PHASE_W-1:0];
                        shift[j] <= pend[j][BEAT_W-1:PHASE_W];
                    end
                    step[NUM_CH-1]  <= beat_data[PHASE_W-1:0];
                    shift[NUM_CH-1] <= beat_data[BEAT_W-1:PHASE_W];
                    beat_idx        <= '0;
                    err_absent      <= !beat_last;
                end else begin
                    pend[beat_idx] <= beat_data;
                    beat_idx       <= beat_idx + 1'b1;
                    err_early      <= beat_last;
                end
            end
        end
    end

endmodule

// File: rtl/dds_tdm2_phase.sv
// Module: shared phase accumulator with a round-robin channel pointer.
// Each cycle it advances the selected channel and registers that channel's
// shifted phase.
// Assumes: step/shift stay stable except at packet commit.
module dds_tdm2_phase #(
    parameter int PHASE_W = 16,
    parameter int NUM_CH  = 2,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0][PHASE_W-1:0] step,
    input  logic [NUM_CH-1:0][PHASE_W-1:0] shift,
    output logic [PHASE_W-1:0]             phase,
    output logic                           phase_valid
);

    logic [PHASE_W-1:0] acc [NUM_CH];
    logic [CH_W-1:0]    ch_sel;

    // Purpose: advance the selected channel, emit its shifted phase, and rotate the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_sel      <= '0;
            phase       <= '0;
            phase_valid <= 1'b0;
            for (int i = 0; i < NUM_CH; i++) acc[i] <= '0;
        end else begin
            phase       <= acc[ch_sel] + shift[ch_sel];
            acc[ch_sel] <= acc[ch_sel] + step[ch_sel];
            ch_sel      <= (ch_sel == CH_W'(NUM_CH - 1)) ? '0 : ch_sel + 1'b1;
            phase_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dds_tdm2_lut.sv
// Module: two-stage sine/cosine lookup.
// Stage one registers the table address (folded into one quadrant in
// quarter-wave mode). Stage two registers the signed amplitude. The phase and
// valid travel alongside, so the output latency is two cycles in both variants.
// Assumes: LUT_AW >= 3, LUT_AW <= PHASE_W, AMP_W >= 2.
module dds_tdm2_lut #(
    parameter int PHASE_W    = 16,
    parameter int AMP_W      = 10,
    parameter int LUT_AW     = 10,
    parameter bit FULL_TABLE = 1'b0,
    localparam int QN        = 1 << (LUT_AW - 2),
    localparam int MAG_W     = AMP_W - 1,
    localparam int AMAX      = (1 << (AMP_W - 1)) - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PHASE_W-1:0]        in_phase,
    input  logic                      in_valid,
    output logic signed [AMP_W-1:0]   sin_out,
    output logic signed [AMP_W-1:0]   cos_out,
    output logic [PHASE_W-1:0]        out_phase,
    output logic                      out_valid
);

    logic [LUT_AW-1:0]  addr_sin;
    logic [LUT_AW-1:0]  addr_cos;
    logic [PHASE_W-1:0] phase_s2;
    logic               valid_s2;

    // Purpose: take the table address from the upper phase bits; cosine leads by a quarter turn.
    always_comb begin
        addr_sin = in_phase[PHASE_W-1 -: LUT_AW];
        addr_cos = addr_sin + LUT_AW'(QN);
    end

    // Purpose: carry phase and valid along the two lookup stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_s2  <= '0;
            valid_s2  <= 1'b0;
            out_phase <= '0;
            out_valid <= 1'b0;
        end else begin
            phase_s2  <= in_phase;
            valid_s2  <= in_valid;
            out_phase <= phase_s2;
            out_valid <= valid_s2;
        end
    end

    generate
        if (FULL_TABLE) begin : g_full
            logic signed [AMP_W-1:0] rom [1 << LUT_AW];
            logic [LUT_AW-1:0]       ra_sin;
            logic [LUT_AW-1:0]       ra_cos;

            for (genvar i = 0; i < (1 << LUT_AW); i++) begin : g_rom
                localparam int Q   = i / QN;
                localparam int K   = i % QN;
                localparam int IDX = (Q % 2 == 1) ? QN - K : K;
                localparam int M   = int'(dds_tdm2_pkg::qwave_mag(64'(IDX), 64'(QN), 64'(AMAX)));
                localparam logic signed [AMP_W-1:0] V = (Q >= 2) ? AMP_W'(-M) : AMP_W'(M);
                assign rom[i] = V;
            end

            // Purpose: register the raw table addresses.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ra_sin <= '0;
                    ra_cos <= '0;
                end else begin
                    ra_sin <= addr_sin;
                    ra_cos <= addr_cos;
                end
            end

            // Purpose: register the signed amplitudes read from the full-wave table.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sin_out <= '0;
                    cos_out <= '0;
                end else begin
                    sin_out <= rom[ra_sin];
                    cos_out <= rom[ra_cos];
                end
            end
        end else begin : g_quarter
            logic [MAG_W-1:0]  qrom [QN + 1];
            logic [LUT_AW-1:0] f_sin;
            logic [LUT_AW-1:0] f_cos;

            for (genvar i = 0; i <= QN; i++) begin : g_rom
                assign qrom[i] = MAG_W'(dds_tdm2_pkg::qwave_mag(64'(i), 64'(QN), 64'(AMAX)));
            end

            // Fold a full-turn address into {negate, quarter index 0..QN}.
            function automatic logic [LUT_AW-1:0] fold(input logic [LUT_AW-1:0] a);
                logic [LUT_AW-2:0] idx;
                idx = a[LUT_AW-2] ? (LUT_AW-1)'(QN) - {1'b0, a[LUT_AW-3:0]}
                                  : {1'b0, a[LUT_AW-3:0]};
                return {a[LUT_AW-1], idx};
            endfunction

            // Purpose: register the folded quadrant addresses and sign flags.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    f_sin <= '0;
                    f_cos <= '0;
                end else begin
                    f_sin <= fold(addr_sin);
                    f_cos <= fold(addr_cos);
                end
            end

            // Purpose: read the magnitudes and apply the quadrant sign.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sin_out <= '0;
                    cos_out <= '0;
                end else begin
                    sin_out <= f_sin[LUT_AW-1] ? -$signed({1'b0, qrom[f_sin[LUT_AW-2:0]]})
                                               :  $signed({1'b0, qrom[f_sin[LUT_AW-2:0]]});
                    cos_out <= f_cos[LUT_AW-1] ? -$signed({1'b0, qrom[f_cos[LUT_AW-2:0]]})
                                               :  $signed({1'b0, qrom[f_cos[LUT_AW-2:0]]});
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dds_tdm2.sv
// Module: two-channel time-shared sine/cosine synthesizer (top).
// It joins the configuration receiver, the shared accumulator and the
// lookup, then packs the amplitudes into sign-extended halves of one word.
// Assumes: the downstream side accepts one beat every cycle (no back-pressure).
module dds_tdm2 #(
    parameter int PHASE_W    = 16,
    parameter int AMP_W      = 10,
    parameter int FIELD_W    = 16,
    parameter int LUT_AW     = 10,
    parameter int NUM_CH     = 2,
    parameter bit FULL_TABLE = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s_cfg_tvalid,
    input  logic [2*PHASE_W-1:0]   s_cfg_tdata,
    input  logic                   s_cfg_tlast,
    output logic                   m_wave_tvalid,
    output logic [2*FIELD_W-1:0]   m_wave_tdata,
    output logic                   m_phase_tvalid,
    output logic [PHASE_W-1:0]     m_phase_tdata,
    output logic                   err_last_absent,
    output logic                   err_last_early
);

    localparam int EXT_W = FIELD_W - AMP_W;

    logic [NUM_CH-1:0][PHASE_W-1:0] step;
    logic [NUM_CH-1:0][PHASE_W-1:0] shift;
    logic [PHASE_W-1:0]             acc_phase;
    logic                           acc_valid;
    logic signed [AMP_W-1:0]        sin_v;
    logic signed [AMP_W-1:0]        cos_v;
    logic [PHASE_W-1:0]             lut_phase;
    logic                           lut_valid;

    dds_tdm2_cfg #(
        .PHASE_W (PHASE_W),
        .NUM_CH  (NUM_CH)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (s_cfg_tvalid),
        .beat_data  (s_cfg_tdata),
        .beat_last  (s_cfg_tlast),
        .step       (step),
        .shift      (shift),
        .err_absent (err_last_absent),
        .err_early  (err_last_early)
    );

    dds_tdm2_phase #(
        .PHASE_W (PHASE_W),
        .NUM_CH  (NUM_CH)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .shift       (shift),
        .phase       (acc_phase),
        .phase_valid (acc_valid)
    );

    dds_tdm2_lut #(
        .PHASE_W    (PHASE_W),
        .AMP_W      (AMP_W),
        .LUT_AW     (LUT_AW),
        .FULL_TABLE (FULL_TABLE)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_phase  (acc_phase),
        .in_valid  (acc_valid),
        .sin_out   (sin_v),
        .cos_out   (cos_v),
        .out_phase (lut_phase),
        .out_valid (lut_valid)
    );

    // Purpose: sign-extend each amplitude into its half; sine high, cosine low.
    always_comb begin
        m_wave_tdata   = {{EXT_W{sin_v[AMP_W-1]}}, sin_v, {EXT_W{cos_v[AMP_W-1]}}, cos_v};
        m_wave_tvalid  = lut_valid;
        m_phase_tdata  = lut_phase;
        m_phase_tvalid = lut_valid;
    end

endmodule

// File: rtl/dds_tdm2_chk.sv
// Module: property checker for dds_tdm2, attached by bind.
// It watches the ports only and keeps a local counter of the cycles since reset.
module dds_tdm2_chk #(
    parameter int AMP_W   = 10,
    parameter int FIELD_W = 16,
    parameter int LAT     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 s_cfg_tvalid,
    input logic                 s_cfg_tlast,
    input logic                 m_wave_tvalid,
    input logic [2*FIELD_W-1:0] m_wave_tdata,
    input logic                 err_last_absent,
    input logic                 err_last_early
);

    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    logic [3:0]         fill_cnt;
    logic [FIELD_W-1:0] cos_f;
    logic [FIELD_W-1:0] sin_f;

    // Purpose: split the output word into its two halves.
    always_comb begin
        cos_f = m_wave_tdata[FIELD_W-1:0];
        sin_f = m_wave_tdata[2*FIELD_W-1:FIELD_W];
    end

    // Purpose: count clock edges since reset release, stopping at the fill latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                fill_cnt <= '0;
        else if (fill_cnt != 4'(LAT)) fill_cnt <= fill_cnt + 1'b1;
    end

    assert_fill_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_wave_tvalid == (fill_cnt == 4'(LAT)));

    assert_valid_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_wave_tvalid |=> m_wave_tvalid);

    assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_wave_tvalid |-> (((&cos_f[FIELD_W-1:AMP_W-1]) || !(|cos_f[FIELD_W-1:AMP_W-1])) &&
                           ((&sin_f[FIELD_W-1:AMP_W-1]) || !(|sin_f[FIELD_W-1:AMP_W-1]))));

    assert_no_most_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_wave_tvalid |-> (cos_f[AMP_W-1:0] != MOST_NEG && sin_f[AMP_W-1:0] != MOST_NEG));

    assert_absent_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_last_absent |-> $past(s_cfg_tvalid && !s_cfg_tlast));

    assert_early_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_last_early |-> $past(s_cfg_tvalid && s_cfg_tlast));

    assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_last_absent, err_last_early}));

endmodule

bind dds_tdm2 dds_tdm2_chk #(
    .AMP_W   (AMP_W),
    .FIELD_W (FIELD_W),
    .LAT     (3)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .s_cfg_tvalid    (s_cfg_tvalid),
    .s_cfg_tlast     (s_cfg_tlast),
    .m_wave_tvalid   (m_wave_tvalid),
    .m_wave_tdata    (m_wave_tdata),
    .err_last_absent (err_last_absent),
    .err_last_early  (err_last_early)
);

// File: tb/dds_tdm2_test.sv
// Scoreboard bench. A reference process pushes one expected phase per clock
// edge. A monitor pops and compares on every valid beat, and checks the
// amplitudes against a real-valued sine.
`timescale 1ns/1ps
module dds_tdm2_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_data = 32'h0;
    logic        cfg_last = 1'b0;
    logic        wave_valid;
    logic [31:0] wave_data;
    logic        ph_valid;
    logic [15:0] ph_data;
    logic        e_absent;
    logic        e_early;

    always #5 clk = ~clk;

    dds_tdm2 uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .s_cfg_tvalid    (cfg_valid),
        .s_cfg_tdata     (cfg_data),
        .s_cfg_tlast     (cfg_last),
        .m_wave_tvalid   (wave_valid),
        .m_wave_tdata    (wave_data),
        .m_phase_tvalid  (ph_valid),
        .m_phase_tdata   (ph_data),
        .err_last_absent (e_absent),
        .err_last_early  (e_early)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R3";

    typedef struct {
        logic [15:0] ph;
        int          ch;
    } exp_t;
    exp_t q[$];

    // reference state, per the requirements
    logic [15:0] m_acc [2];
    logic [15:0] m_inc [2];
    logic [15:0] m_off [2];
    logic [31:0] m_pend;
    int          m_ch, m_idx, edges;
    logic        m_abs, m_early;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference: push the expected phase per edge, then apply any config beat
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_acc[i] = 16'h0; m_inc[i] = 16'h0; m_off[i] = 16'h0;
            end
            m_pend = 32'h0; m_ch = 0; m_idx = 0; edges = 0;
            m_abs = 1'b0; m_early = 1'b0;
            q.delete();
        end else begin
            exp_t e;
            e.ph = m_acc[m_ch] + m_off[m_ch];
            e.ch = m_ch;
            q.push_back(e);
            m_acc[m_ch] = m_acc[m_ch] + m_inc[m_ch];
            m_ch ^= 1;
            m_abs = 1'b0; m_early = 1'b0;
            if (cfg_valid) begin  // R10: nothing happens when valid is low
                if (m_idx == 0) begin
                    m_pend = cfg_data; m_idx = 1; m_early = cfg_last;
                end else begin
                    m_inc[0] = m_pend[15:0];   m_off[0] = m_pend[31:16];
                    m_inc[1] = cfg_data[15:0]; m_off[1] = cfg_data[31:16];
                    m_idx = 0; m_abs = !cfg_last;
                end
            end
            edges++;
        end
    end

    // monitor: sample half a cycle after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(wave_valid == (edges >= 3), "R3", "wave valid", int'(wave_valid), int'(edges >= 3));
            check(ph_valid == (edges >= 3), "R3", "phase valid", int'(ph_valid), int'(edges >= 3));
            check(e_absent == m_abs, "R8", "absent-marker event", int'(e_absent), int'(m_abs));
            check(e_early == m_early, "R9", "early-marker event", int'(e_early), int'(m_early));
            if (wave_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1", "beat with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    int   k, s, c, rs, rc;
                    real  ang;
                    e = q.pop_front();
                    check(ph_data == e.ph, tag, $sformatf("phase ch%0d", e.ch),
                          int'(ph_data), int'(e.ph));
                    check((wave_data[15:9] == 7'h00) || (wave_data[15:9] == 7'h7f), "R4",
                          "cosine sign extension", int'(wave_data[15:0]), int'(wave_data[9]));
                    check((wave_data[31:25] == 7'h00) || (wave_data[31:25] == 7'h7f), "R4",
                          "sine sign extension", int'(wave_data[31:16]), int'(wave_data[25]));
                    k   = int'(e.ph[15:6]);
                    s   = int'($signed(wave_data[25:16]));
                    c   = int'($signed(wave_data[9:0]));
                    ang = 2.0 * 3.14159265358979 * real'(k) / 1024.0;
                    rs  = int'(511.0 * $sin(ang));
                    rc  = int'(511.0 * $cos(ang));
                    check((s - rs <= 2) && (rs - s <= 2), "R5", "sine accuracy", s, rs);
                    check((c - rc <= 2) && (rc - c <= 2), "R5", "cosine accuracy", c, rc);
                    if (k == 0)   begin check(s == 0,    "R5", "sine at 0",    s, 0);    check(c == 511,  "R5", "cosine at 0",   c, 511);  end
                    if (k == 256) begin check(s == 511,  "R5", "sine at 1/4",  s, 511);  check(c == 0,    "R5", "cosine at 1/4", c, 0);    end
                    if (k == 512) begin check(s == 0,    "R5", "sine at 1/2",  s, 0);    check(c == -511, "R5", "cosine at 1/2", c, -511); end
                    if (k == 768) begin check(s == -511, "R5", "sine at 3/4",  s, -511); check(c == 0,    "R5", "cosine at 3/4", c, 0);    end
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // one beat; idle cycles afterwards carry junk data and a raised marker (R10)
    task automatic beat(input logic [15:0] inc, input logic [15:0] off, input logic last);
        cfg_valid = 1'b1;
        cfg_data  = {off, inc};
        cfg_last  = last;
        tick(1);
        cfg_valid = 1'b0;
        cfg_data  = 32'hDEAD_BEEF;
        cfg_last  = 1'b1;
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tag = "R3"; tick(8);                                       // zero config, exact points
        tag = "R6"; beat(16'd1310, 16'h0000, 1'b0); beat(16'd2620, 16'h4000, 1'b1); tick(60);
        tag = "R1"; tick(20);
        // mid-run reset, then quarter-turn steps for exact amplitude points
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        tag = "R5"; beat(16'h4000, 16'h0000, 1'b0); beat(16'h1000, 16'hC000, 1'b1); tick(40);
        // partial packet: first beat, long idle with junk, then second beat
        tag = "R7"; beat(16'd7, 16'h0100, 1'b0); tick(20);
        tag = "R10"; tick(10);
        tag = "R7"; beat(16'd9, 16'h0200, 1'b1); tick(20);
        tag = "R8"; beat(16'd300, 16'h0000, 1'b0); beat(16'd500, 16'h1234, 1'b0); tick(20);
        tag = "R9"; beat(16'd111, 16'h0000, 1'b1); beat(16'd222, 16'h0000, 1'b1); tick(20);
        // back-to-back packets and modulo wrap with large steps
        tag = "R2"; beat(16'hFFFF, 16'hFFF0, 1'b0); beat(16'hF001, 16'h8000, 1'b1);
        beat(16'hFFFE, 16'h0010, 1'b0); beat(16'h7FFF, 16'hFFFF, 1'b1); tick(60);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule